// File: doc/BRIEF.md
# SPI Flash Command Engine

This block lets a processor run one serial-flash command at a time through three 32-bit registers. Software writes a command word (command byte plus a 24-bit flash address) and, when the command carries payload, up to four bytes into a data register. It then writes the control register with a transmit byte count, a receive byte count and the start bit. The engine drops chip select, shifts out the command byte, the three address bytes and the payload, then clocks in the requested response bytes. It packs the response bytes into the data register, lowest byte first.

The transmit count covers every byte sent, so a bare command uses 1, an erase with an address uses 4 and an address plus four payload bytes uses 8. A busy flag in the control register stays set for the whole frame. Software polls it before touching any register again. While busy is set, register writes are dropped.

The serial side runs in clock mode 0. A two-bit clock-select field divides the system clock by 2, 4, 8 or 16. The transfer engine is a five-state machine. IDLE moves to LEAD on an accepted start. LEAD moves to HIGH after one half period. HIGH moves to LOW after a half period, or to TRAIL after the last bit of the last byte. LOW moves back to HIGH after a half period. TRAIL moves to IDLE after a half period.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset all three registers read 0, chip select is high (inactive), and the serial clock and data-out pins are low.
- R2: The control register is at offset 0x0, the command register at 0x4 and the data register at 0x8. Control fields are stored and read back as follows: bits 3:0 transmit count, bits 7:4 receive count, bits 18:17 size, bits 25:24 clock select. Bit 8 (start) and all unlisted bits read 0. The command and data registers read back all 32 bits.
- R3: A control write with bit 8 set and a nonzero transmit-plus-receive count starts a frame, and bit 16 (busy) reads 1 from the next cycle until the frame ends. A start write with both counts zero starts nothing.
- R4: Frame byte k on the data-out pin comes from these sources: k=0 from command bits 7:0; k=1, 2 and 3 from command bits 31:24, 23:16 and 15:8; k=4..7 from data bytes 0..3 (bits 7:0 first). Transmit bytes at k of 8 or more are 0x00. Each byte is sent most significant bit first, and data-out is 0 during receive bytes.
- R5: Receive byte j (frame byte transmit count + j), for j below 4, is written into data bits 8j+7:8j. Data bytes that receive no byte keep their value, and receive bytes beyond the fourth are discarded.
- R6: The serial clock idles low. Data-out changes only while the serial clock is low, and data-in is sampled on each rising edge.
- R7: Chip select goes low before the first rising clock edge and rises once per frame, after the last bit, with the clock low.
- R8: A clock select of s gives a serial clock period of 2^(s+1) system clocks.
- R9: While busy is set, writes to all three registers are ignored.
- R10: A frame produces exactly 8 x (transmit count + receive count) rising serial clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Four behaviours are checked by assertions on every cycle: the command, data and control registers hold still while busy (apart from the engine's own receive writes), an accepted start always raises busy, data-out never moves while the serial clock is high, and chip select is already low one cycle before any rising clock edge. Only the bench's frames can show the rest. That covers the byte order on the wire, where received bytes land in the data register, the clock divide for each select value, the edge count and single chip-select release per frame, and the rejection of zero-length starts.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL
    } xfer_state_e;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_CMD  = 4'h4;
    localparam logic [3:0] OFS_DATA = 4'h8;

    localparam int START_BIT = 8;
    localparam int BUSY_BIT  = 16;
    localparam int SIZE_LSB  = 17;
    localparam int SEL_LSB   = 24;

    // Byte k of the outgoing frame: command byte, address high to low, payload low to high.
    function automatic logic [7:0] tx_pick(input logic [31:0] cmd,
                                           input logic [31:0] dat,
                                           input logic [4:0]  idx);
        logic [7:0] b;
        case (idx)
            5'd0:    b = cmd[7:0];
            5'd1:    b = cmd[31:24];
            5'd2:    b = cmd[23:16];
            5'd3:    b = cmd[15:8];
            5'd4:    b = dat[7:0];
            5'd5:    b = dat[15:8];
            5'd6:    b = dat[23:16];
            5'd7:    b = dat[31:24];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sfc_regfile.sv
module sfc_regfile
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy_i,
    input  logic              rx_we_i,
    input  logic [1:0]        rx_lane_i,
    input  logic [7:0]        rx_byte_i,
    output logic              go_o,
    output logic [CNT_W-1:0]  tx_cnt_o,
    output logic [CNT_W-1:0]  rx_cnt_o,
    output logic [SEL_W-1:0]  clk_sel_o,
    output logic [31:0]       cmd_o,
    output logic [31:0]       data_o
);

    logic [1:0]  size_q;
    logic        wr_ok;
    logic        unused_wbits;

    assign wr_ok = we && !busy_i;
    assign go_o  = wr_ok && (addr == OFS_CTRL) && wdata[START_BIT] &&
                   ((wdata[CNT_W-1:0] != '0) || (wdata[2*CNT_W-1:CNT_W] != '0));
    assign unused_wbits = ^{wdata[31:26], wdata[23:19], wdata[16:9]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_cnt_o  <= '0;
            rx_cnt_o  <= '0;
            size_q    <= '0;
            clk_sel_o <= '0;
            cmd_o     <= '0;
            data_o    <= '0;
        end else begin
            if (wr_ok) begin
                if (addr == OFS_CTRL) begin
                    tx_cnt_o  <= wdata[CNT_W-1:0];
                    rx_cnt_o  <= wdata[2*CNT_W-1:CNT_W];
                    size_q    <= wdata[SIZE_LSB+:2];
                    clk_sel_o <= wdata[SEL_LSB+:SEL_W];
                end
                if (addr == OFS_CMD)  cmd_o  <= wdata;
                if (addr == OFS_DATA) data_o <= wdata;
            end
            if (rx_we_i) data_o[8*rx_lane_i+:8] <= rx_byte_i;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[CNT_W-1:0]        = tx_cnt_o;
                rdata[2*CNT_W-1:CNT_W]  = rx_cnt_o;
                rdata[BUSY_BIT]         = busy_i;
                rdata[SIZE_LSB+:2]      = size_q;
                rdata[SEL_LSB+:SEL_W]   = clk_sel_o;
            end
            OFS_CMD:  rdata = cmd_o;
            OFS_DATA: rdata = data_o;
            default:  rdata = '0;
        endcase
    end

    // R9: software writes never reach the registers during a frame
    p_cmd_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(cmd_o));
    p_data_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !rx_we_i) |=> $stable(data_o));
    p_ctrl_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(tx_cnt_o) && $stable(rx_cnt_o) && $stable(clk_sel_o)));

endmodule

// File: rtl/sfc_xfer.sv
module sfc_xfer
    import sfc_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic [SEL_W-1:0] clk_sel_i,
    input  logic [31:0]      cmd_i,
    input  logic [31:0]      data_i,
    input  logic             spi_miso,
    output logic             busy_o,
    output logic             rx_we_o,
    output logic [1:0]       rx_lane_o,
    output logic [7:0]       rx_byte_o,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic             spi_mosi
);

    localparam int HCNT_W = 2 ** SEL_W;
    localparam int IDX_W  = CNT_W + 1;

    xfer_state_e        state_q, state_d;
    logic [HCNT_W-1:0]  half_q;
    logic [HCNT_W-1:0]  half_lim;
    logic [2:0]         bit_q;
    logic [IDX_W-1:0]   byte_q;
    logic [7:0]         shreg_q;
    logic [IDX_W-1:0]   total;
    logic [IDX_W-1:0]   rx_pos;
    logic [7:0]         tx_cur;
    logic               tick;
    logic               last_byte;
    logic               in_tx;

    assign half_lim  = (HCNT_W'(1) << clk_sel_i) - HCNT_W'(1);
    assign tick      = (half_q == half_lim);
    assign total     = IDX_W'(tx_cnt_i) + IDX_W'(rx_cnt_i);
    assign last_byte = (byte_q == total - IDX_W'(1));
    assign in_tx     = (byte_q < IDX_W'(tx_cnt_i));
    assign rx_pos    = byte_q - IDX_W'(tx_cnt_i);
    assign tx_cur    = tx_pick(cmd_i, data_i, byte_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go_i) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_HIGH;
            ST_HIGH:  if (tick) state_d = (bit_q == 3'd0 && last_byte) ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (tick) state_d = ST_HIGH;
            ST_TRAIL: if (tick) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= '0;
            bit_q   <= 3'd7;
            byte_q  <= '0;
            shreg_q <= '0;
        end else begin
            half_q <= (state_q == ST_IDLE || tick) ? '0 : half_q + HCNT_W'(1);
            if (state_q == ST_IDLE && go_i) begin
                bit_q  <= 3'd7;
                byte_q <= '0;
            end
            if ((state_q == ST_LEAD || state_q == ST_LOW) && tick)
                shreg_q <= {shreg_q[6:0], spi_miso};
            if (state_q == ST_HIGH && tick) begin
                if (bit_q == 3'd0) begin
                    bit_q  <= 3'd7;
                    byte_q <= byte_q + IDX_W'(1);
                end else begin
                    bit_q <= bit_q - 3'd1;
                end
            end
        end
    end

    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        spi_cs_n  = (state_q == ST_IDLE);
        spi_sck   = (state_q == ST_HIGH);
        spi_mosi  = busy_o && in_tx && tx_cur[bit_q];
        rx_we_o   = (state_q == ST_HIGH) && tick && (bit_q == 3'd0) && !in_tx &&
                    (rx_pos < IDX_W'(4));
        rx_lane_o = rx_pos[1:0];
        rx_byte_o = shreg_q;
    end

    // R3: an accepted start always opens a frame
    p_go_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> busy_o);
    // R6: outgoing data is steady while the clock is high
    p_mosi_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi));
    // R7: chip select already active before any rising clock edge
    p_cs_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $past(!spi_cs_n));

endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic             busy;
    logic             go;
    logic             rx_we;
    logic [1:0]       rx_lane;
    logic [7:0]       rx_byte;
    logic [CNT_W-1:0] tx_cnt;
    logic [CNT_W-1:0] rx_cnt;
    logic [SEL_W-1:0] clk_sel;
    logic [31:0]      cmd_w;
    logic [31:0]      data_w;

    sfc_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy_i    (busy),
        .rx_we_i   (rx_we),
        .rx_lane_i (rx_lane),
        .rx_byte_i (rx_byte),
        .go_o      (go),
        .tx_cnt_o  (tx_cnt),
        .rx_cnt_o  (rx_cnt),
        .clk_sel_o (clk_sel),
        .cmd_o     (cmd_w),
        .data_o    (data_w)
    );

    sfc_xfer #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .tx_cnt_i  (tx_cnt),
        .rx_cnt_i  (rx_cnt),
        .clk_sel_i (clk_sel),
        .cmd_i     (cmd_w),
        .data_i    (data_w),
        .spi_miso  (spi_miso),
        .busy_o    (busy),
        .rx_we_o   (rx_we),
        .rx_lane_o (rx_lane),
        .rx_byte_o (rx_byte),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi)
    );

endmodule

// File: tb/sflash_cmd_engine_bench.sv
module sflash_cmd_engine_bench;

    typedef struct packed {
        logic [3:0]  tx;
        logic [3:0]  rx;
        logic [1:0]  sel;
        logic [31:0] cmd;
        logic [31:0] dat;
        logic [7:0]  base;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 4'd1, 2'd0, 32'h0000_0005, 32'hDEAD_BEEF, 8'h40, 32'hDEAD_BE41},
        '{4'd4, 4'd1, 2'd1, 32'h0000_00AB, 32'h1122_3344, 8'h10, 32'h1122_3314},
        '{4'd4, 4'd4, 2'd2, 32'h1234_5603, 32'h0000_0000, 8'h80, 32'h8786_8584},
        '{4'd8, 4'd0, 2'd3, 32'h0001_0002, 32'hA5B6_C7D8, 8'h00, 32'hA5B6_C7D8},
        '{4'd1, 4'd2, 2'd0, 32'h0000_009F, 32'hCAFE_F00D, 8'h20, 32'hCAFE_2221},
        '{4'd2, 4'd6, 2'd0, 32'h0000_0000, 32'h0000_0000, 8'h30, 32'h3534_3332}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    // simple flash model: frame byte k answers with base + k
    logic [7:0] resp_base = 8'h00;
    int         bitn = 0;
    logic [7:0] shin = 8'h00;
    logic [7:0] cap [16];
    int         sck_rises = 0;
    int         cs_rises = 0;
    realtime    last_rise = 0.0;
    realtime    sck_per = 0.0;
    logic [7:0] rb;

    assign rb = resp_base + 8'(bitn / 8);
    assign spi_miso = spi_cs_n ? 1'b0 : rb[7 - (bitn % 8)];

    always #10 clk = ~clk;

    always @(posedge clk) cycles++;

    always @(posedge spi_sck) begin
        shin = {shin[6:0], spi_mosi};
        bitn++;
        sck_rises++;
        if (bitn % 8 == 0 && bitn / 8 <= 16) cap[bitn / 8 - 1] = shin;
        sck_per = $realtime - last_rise;
        last_rise = $realtime;
    end

    always @(posedge spi_cs_n) cs_rises++;

    sflash_cmd_engine u_sflash_cmd_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        do begin
            rd(4'h0, c);
            if (cycles > 150000) begin
                chk(1'b0, "watchdog", cycles, 150000);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end while (c[16]);
    endtask

    function automatic logic [7:0] exp_tx(input logic [31:0] cmd, input logic [31:0] dat, input int k);
        if (k == 0) return cmd[7:0];
        if (k < 4)  return 8'(cmd >> (8 * (4 - k)));
        if (k < 8)  return 8'(dat >> (8 * (k - 4)));
        return 8'h00;
    endfunction

    task automatic arm(input vec_t v);
        wr(4'h4, v.cmd);
        wr(4'h8, v.dat);
        resp_base = v.base;
        bitn = 0; sck_rises = 0; cs_rises = 0;
    endtask

    task automatic frame_checks(input vec_t v);
        logic [31:0] d;
        bit ok;
        rd(4'h8, d);
        chk(d == v.exp, "R5 data after frame", d, v.exp);
        ok = 1'b1;
        for (int k = 0; k < int'(v.tx); k++)
            if (cap[k] != exp_tx(v.cmd, v.dat, k)) ok = 1'b0;
        for (int k = int'(v.tx); k < int'(v.tx) + int'(v.rx); k++)
            if (cap[k] != 8'h00) ok = 1'b0;
        chk(ok, "R4 R6 wire bytes", {24'h0, cap[0]}, {24'h0, exp_tx(v.cmd, v.dat, 0)});
        chk(sck_per == real'(40 << v.sel), "R8 sck period ns", 32'(int'(sck_per)), 32'(40 << v.sel));
        chk(sck_rises == 8 * (int'(v.tx) + int'(v.rx)), "R10 edge count",
            sck_rises, 8 * (int'(v.tx) + int'(v.rx)));
        chk(cs_rises == 1 && spi_cs_n && !spi_sck, "R7 cs release", cs_rises, 1);
    endtask

    initial begin
        logic [31:0] r;
        vec_t lv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, r); chk(r == 0, "R1 ctrl reset", r, 0);
        rd(4'h4, r); chk(r == 0, "R1 cmd reset", r, 0);
        rd(4'h8, r); chk(r == 0, "R1 data reset", r, 0);
        chk(spi_cs_n && !spi_sck && !spi_mosi, "R1 pins idle", {spi_cs_n, spi_sck, spi_mosi}, 3'b100);

        // R2 layout and readback
        wr(4'h0, 32'hFFFF_FEFF);
        rd(4'h0, r); chk(r == 32'h0306_00FF, "R2 ctrl fields", r, 32'h0306_00FF);
        wr(4'h0, 32'h0102_0021);
        rd(4'h0, r); chk(r == 32'h0102_0021, "R2 ctrl fields 2", r, 32'h0102_0021);
        wr(4'h4, 32'h89AB_CDEF);
        rd(4'h4, r); chk(r == 32'h89AB_CDEF, "R2 cmd readback", r, 32'h89AB_CDEF);
        wr(4'h8, 32'h0F1E_2D3C);
        rd(4'h8, r); chk(r == 32'h0F1E_2D3C, "R2 data readback", r, 32'h0F1E_2D3C);

        // R3 zero-length start is ignored
        wr(4'h0, 32'h0000_0100);
        rd(4'h0, r);
        chk(r == 0 && spi_cs_n, "R3 zero-count start", r, 0);

        // table of frames
        for (int i = 0; i < NV; i++) begin
            arm(VECS[i]);
            wr(4'h0, {6'h0, VECS[i].sel, 15'h0, 1'b1, VECS[i].rx, VECS[i].tx});
            rd(4'h0, r);
            chk(r[16] && !spi_cs_n, "R3 busy during frame", r, 32'h0001_0000);
            wait_idle();
            frame_checks(VECS[i]);
        end

        // R9 writes during a frame are dropped
        lv = VECS[3];
        arm(lv);
        wr(4'h0, 32'h0300_0108);
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h8, 32'h0000_0000);
        wr(4'h0, 32'h0000_0111);
        wait_idle();
        frame_checks(lv);
        rd(4'h4, r); chk(r == lv.cmd, "R9 cmd held", r, lv.cmd);
        rd(4'h0, r); chk(r == 32'h0300_0008, "R9 ctrl held", r, 32'h0300_0008);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #3000000;
        chk(1'b0, "watchdog timeout", cycles, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule